// File: doc/BRIEF.md
# CCD Vertical Sequence Timing Generator

This block produces the vertical transfer clocks for one line of a CCD readout, together with the line-end marker and three per-line level signals: clamp, pixel blank and horizontal blank. A 13-bit pixel counter runs on the pixel clock. It restarts at the end of each line, so each line holds up to 8192 pixels. The normal line length applies to most lines. A second length applies while the last-line input is high.

Inside each line, two playback engines step through a stored pattern group. Each engine starts at its own start pixel. It repeats the group a number of times, and that number depends on the line-parity input. The vertical outputs are split into four equal subsets. Each subset has its own group-select value, so different outputs can follow different groups during the same line. Two freeze/resume windows can pause playback. While a window is active, the outputs are held.

The three level signals are each defined by a start polarity and a set of toggle positions within the line. The pattern table, the lengths and all positions arrive as plain input vectors.

Top module: `vseq_timing_gen`

## Requirements
- R1: `line_m1` holds the line length minus one. `eol_o` is high for exactly one clock, during the cycle that reports pixel `line_m1`, and the next reported pixel is 0.
- R2: While `last_line` is high, `last_m1` replaces `line_m1` as the line length minus one.
- R3: All outputs are registered. The values seen after the clock edge that consumes pixel p describe pixel p. From pixel `start_a` onward, engine A reports pattern step k mod (`pat_m1`+1) at pixel `start_a`+k.
- R4: Vertical output bits [2k+1:2k] form subset k, for k = 0 to 3. Subset k shows the same bit positions of group `grp_sel[2k+1:2k]`. Subsets 0 and 1 follow engine A (`start_a`) and subsets 2 and 3 follow engine B (`start_b`). Group g, step s, output bit b is stored at `pat_tbl` bit (g*16+s)*8+b.
- R5: A line plays the group `rep_odd` times when `line_odd` is 1 and `rep_even` times otherwise. A count of 0 plays it once.
- R6: Outside a playback, each vertical output holds its last value. A playback still running at the last pixel of a line is cut off there and does not continue into the next line.
- R7: Window w covers pixels p with `frz_pos[w]` <= p < `res_pos[w]`, and it is active when `frz_en[w]` is set. While `mask_en` is 1 and p lies in an active window, the vertical outputs hold and the step count pauses. Playback then continues from the paused step.
- R8: With `mask_en` at 0, the freeze windows have no effect on the vertical outputs.
- R9: At pixel p, signal i (0 = clamp, 1 = pixel blank, 2 = horizontal blank) equals `tg_pol[i]` XOR the parity of the number of its two positions `tg_pos[(2i+j)*13 +: 13]` that are less than or equal to p.
- R10: While `rst_n` is low, the vertical outputs, `eol_o` and the three level signals are 0. The first pixel reported after release is pixel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_odd | input | 1 | Parity of the current line (1 = odd) |
| last_line | input | 1 | Current line is the last line of the field |
| line_m1 | input | 13 | Normal line length minus one |
| last_m1 | input | 13 | Last-line length minus one |
| start_a | input | 13 | Start pixel of engine A |
| start_b | input | 13 | Start pixel of engine B |
| rep_odd | input | 8 | Playback count on odd lines |
| rep_even | input | 8 | Playback count on even lines |
| pat_m1 | input | 4 | Pattern group length in steps, minus one |
| grp_sel | input | 8 | Four 2-bit group selects, one per output subset |
| pat_tbl | input | 512 | Pattern table, 4 groups x 16 steps x 8 outputs |
| mask_en | input | 1 | Allow the freeze windows to hold the outputs |
| frz_en | input | 2 | Enable for each freeze window |
| frz_pos | input | 26 | Freeze pixel of each window |
| res_pos | input | 26 | Resume pixel of each window |
| tg_pol | input | 3 | Start polarity of clamp, pixel blank and horizontal blank |
| tg_pos | input | 78 | Two toggle positions for each of the three signals |
| vout_o | output | 8 | Vertical transfer outputs |
| eol_o | output | 1 | Last pixel of the line |
| clamp_o | output | 1 | Clamp signal |
| pblank_o | output | 1 | Pixel blanking signal |
| hblank_o | output | 1 | Horizontal blanking signal |

## Verification
The assertions assume three things about the inputs. Configuration changes only while reset is held. Parity and last-line change only as a line starts. Both line lengths are at least two pixels, so a line-end pulse can never be followed by another one. The bench follows these rules: it changes settings inside a reset, updates `line_odd` and `last_line` only just before pixel 0, and uses lines of 12 to 40 pixels. It also places each start pixel outside every enabled freeze window, because a start pixel that falls inside a window is skipped for that line.

// File: rtl/vseq_timing_gen.sv
module vseq_timing_gen #(
  parameter int NV    = 8,
  parameter int NGRP  = 4,
  parameter int NSTEP = 16,
  parameter int CW    = 13,
  parameter int RW    = 8,
  parameter int NTOG  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        line_odd,
  input  logic                        last_line,
  input  logic [CW-1:0]               line_m1,
  input  logic [CW-1:0]               last_m1,
  input  logic [CW-1:0]               start_a,
  input  logic [CW-1:0]               start_b,
  input  logic [RW-1:0]               rep_odd,
  input  logic [RW-1:0]               rep_even,
  input  logic [$clog2(NSTEP)-1:0]    pat_m1,
  input  logic [4*$clog2(NGRP)-1:0]   grp_sel,
  input  logic [NGRP*NSTEP*NV-1:0]    pat_tbl,
  input  logic                        mask_en,
  input  logic [1:0]                  frz_en,
  input  logic [2*CW-1:0]             frz_pos,
  input  logic [2*CW-1:0]             res_pos,
  input  logic [2:0]                  tg_pol,
  input  logic [3*NTOG*CW-1:0]        tg_pos,
  output logic [NV-1:0]               vout_o,
  output logic                        eol_o,
  output logic                        clamp_o,
  output logic                        pblank_o,
  output logic                        hblank_o
);
  localparam int GW   = $clog2(NGRP);
  localparam int SW   = $clog2(NSTEP);
  localparam int SUBW = NV / 4;

  logic [CW-1:0] cnt;
  logic [CW-1:0] act_m1;
  logic          last_px;
  logic [RW-1:0] reps;
  logic [RW-1:0] reps_m1;
  logic          hold;
  logic [1:0]    win;
  logic [1:0]    fire;
  logic [SW-1:0] cstep [2];
  logic [2:0]    tg_nxt;

  assign act_m1  = last_line ? last_m1 : line_m1;
  assign last_px = (cnt == act_m1);
  assign reps    = line_odd ? rep_odd : rep_even;
  assign reps_m1 = (reps == '0) ? '0 : reps - RW'(1);

  for (genvar w = 0; w < 2; w++) begin : g_win
    assign win[w] = frz_en[w] && (cnt >= frz_pos[w*CW +: CW]) && (cnt < res_pos[w*CW +: CW]);
  end
  assign hold = mask_en && (|win);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      eol_o <= 1'b0;
    end else begin
      cnt   <= last_px ? '0 : cnt + CW'(1);
      eol_o <= last_px;
    end
  end

  for (genvar e = 0; e < 2; e++) begin : g_eng
    logic          act;
    logic          go;
    logic [SW-1:0] step;
    logic [SW-1:0] cs;
    logic [RW-1:0] rep;
    logic [RW-1:0] cr;
    logic [CW-1:0] st;

    assign st       = (e == 0) ? start_a : start_b;
    assign go       = act || (cnt == st);
    assign cs       = act ? step : '0;
    assign cr       = act ? rep : '0;
    assign fire[e]  = go && !hold;
    assign cstep[e] = cs;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act  <= 1'b0;
        step <= '0;
        rep  <= '0;
      end else begin
        if (go && !hold) begin
          if (cs == pat_m1) begin
            step <= '0;
            if (cr == reps_m1) begin
              act <= 1'b0;
              rep <= '0;
            end else begin
              act <= 1'b1;
              rep <= cr + RW'(1);
            end
          end else begin
            act  <= 1'b1;
            step <= cs + SW'(1);
            rep  <= cr;
          end
        end
        if (last_px) act <= 1'b0;
      end
    end
  end

  function automatic logic [SUBW-1:0] pick(input int g, input int s, input int k);
    return pat_tbl[(g*NSTEP + s)*NV + k*SUBW +: SUBW];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vout_o <= '0;
    end else begin
      for (int k = 0; k < 4; k++)
        if (fire[k/2])
          vout_o[k*SUBW +: SUBW] <= pick(int'(grp_sel[k*GW +: GW]), int'(cstep[k/2]), k);
    end
  end

  always_comb begin
    tg_nxt = tg_pol;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < NTOG; j++)
        if (tg_pos[(i*NTOG + j)*CW +: CW] <= cnt) tg_nxt[i] = ~tg_nxt[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {hblank_o, pblank_o, clamp_o} <= 3'b000;
    else        {hblank_o, pblank_o, clamp_o} <= tg_nxt;
  end
endmodule

// File: rtl/vseq_timing_gen_chk.sv
module vseq_timing_gen_chk #(
  parameter int NV   = 8,
  parameter int CW   = 13,
  parameter int NTOG = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CW-1:0]        cnt,
  input logic                 hold,
  input logic                 eol_o,
  input logic                 last_line,
  input logic [CW-1:0]        line_m1,
  input logic [CW-1:0]        last_m1,
  input logic [NV-1:0]        vout_o,
  input logic                 clamp_o,
  input logic                 pblank_o,
  input logic                 hblank_o,
  input logic [3*NTOG*CW-1:0] tg_pos
);
  logic [2:0] hit;
  always_comb begin
    hit = '0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < NTOG; j++)
        if (tg_pos[(i*NTOG + j)*CW +: CW] == cnt) hit[i] = 1'b1;
  end

  p_eol_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (eol_o && line_m1 != '0 && last_m1 != '0) |=> !eol_o);

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (last_line ? last_m1 : line_m1));

  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(vout_o));

  p_clamp_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !hit[0]) |=> $stable(clamp_o));

  p_pblank_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !hit[1]) |=> $stable(pblank_o));

  p_hblank_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !hit[2]) |=> $stable(hblank_o));

  always @(posedge clk)
    if (!rst_n)
      p_reset_zero_r10: assert (vout_o == '0 && !eol_o && !clamp_o && !pblank_o && !hblank_o);
endmodule

bind vseq_timing_gen vseq_timing_gen_chk #(.NV(NV), .CW(CW), .NTOG(NTOG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .hold(hold), .eol_o(eol_o),
  .last_line(last_line), .line_m1(line_m1), .last_m1(last_m1),
  .vout_o(vout_o), .clamp_o(clamp_o), .pblank_o(pblank_o),
  .hblank_o(hblank_o), .tg_pos(tg_pos)
);

// File: tb/tb_vseq_timing_gen.sv
module tb_vseq_timing_gen;
  localparam int PERIOD = 10;
  localparam int NV = 8, NGRP = 4, NSTEP = 16, CW = 13, RW = 8, NTOG = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_odd = 1'b0, last_line = 1'b0;
  logic [CW-1:0] line_m1, last_m1, start_a, start_b;
  logic [RW-1:0] rep_odd, rep_even;
  logic [3:0] pat_m1;
  logic [7:0] grp_sel;
  logic [NGRP*NSTEP*NV-1:0] pat_tbl;
  logic mask_en;
  logic [1:0] frz_en;
  logic [2*CW-1:0] frz_pos, res_pos;
  logic [2:0] tg_pol;
  logic [3*NTOG*CW-1:0] tg_pos;
  logic [NV-1:0] vout_o;
  logic eol_o, clamp_o, pblank_o, hblank_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [NV-1:0] ev;

  always #(PERIOD/2) clk = ~clk;

  vseq_timing_gen #(.NV(NV), .NGRP(NGRP), .NSTEP(NSTEP), .CW(CW), .RW(RW), .NTOG(NTOG)) dut (
    .clk(clk), .rst_n(rst_n), .line_odd(line_odd), .last_line(last_line),
    .line_m1(line_m1), .last_m1(last_m1), .start_a(start_a), .start_b(start_b),
    .rep_odd(rep_odd), .rep_even(rep_even), .pat_m1(pat_m1), .grp_sel(grp_sel),
    .pat_tbl(pat_tbl), .mask_en(mask_en), .frz_en(frz_en), .frz_pos(frz_pos),
    .res_pos(res_pos), .tg_pol(tg_pol), .tg_pos(tg_pos), .vout_o(vout_o),
    .eol_o(eol_o), .clamp_o(clamp_o), .pblank_o(pblank_o), .hblank_o(hblank_o));

  function automatic logic [NV-1:0] patv(input int g, input int s);
    return NV'((s*(g+3)*29 + g*83 + s*s*7 + 5) % 256);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit held(input int q);
    bit h0, h1;
    h0 = frz_en[0] && q >= int'(frz_pos[0 +: CW]) && q < int'(res_pos[0 +: CW]);
    h1 = frz_en[1] && q >= int'(frz_pos[CW +: CW]) && q < int'(res_pos[CW +: CW]);
    return mask_en && (h0 || h1);
  endfunction

  task automatic rst_on();
    rst_n = 1'b0;
    mask_en = 0; frz_en = 0; frz_pos = '1; res_pos = '1;
    rep_odd = 1; rep_even = 1; pat_m1 = 3; grp_sel = 8'he4;
    start_a = 2; start_b = 4; line_m1 = 29; last_m1 = 29;
    tg_pol = 3'b000;
    tg_pos = {13'd20, 13'd9, 13'd14, 13'd5, 13'd11, 13'd3};
  endtask

  task automatic rst_off();
    repeat (2) @(negedge clk);
    chk("R10", {vout_o, eol_o, clamp_o, pblank_o, hblank_o}, 0);
    ev = '0;
    rst_n = 1'b1;
  endtask

  task automatic run_line(input bit odd, input bit last, input string vtag);
    int len, reps, tot, st, played, g, L;
    logic [NV-1:0] pv;
    logic [2:0] te;
    line_odd = odd; last_line = last;
    L = last ? int'(last_m1) + 1 : int'(line_m1) + 1;
    len = int'(pat_m1) + 1;
    reps = odd ? int'(rep_odd) : int'(rep_even);
    if (reps == 0) reps = 1;
    tot = len * reps;
    for (int p = 0; p < L; p++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        st = (k < 2) ? int'(start_a) : int'(start_b);
        if (p >= st && !held(p)) begin
          played = 0;
          for (int q = st; q <= p; q++) if (!held(q)) played++;
          if (played <= tot) begin
            g = int'(grp_sel[k*2 +: 2]);
            pv = patv(g, (played - 1) % len);
            ev[k*2 +: 2] = pv[k*2 +: 2];
          end
        end
      end
      chk(vtag, vout_o, ev);
      chk(last ? "R2" : "R1", eol_o, (p == L - 1));
      te = tg_pol;
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < NTOG; j++)
          if (int'(tg_pos[(i*NTOG + j)*CW +: CW]) <= p) te[i] = ~te[i];
      chk("R9", {hblank_o, pblank_o, clamp_o}, te);
    end
  endtask

  task automatic t_reset();
    rst_on();
    line_m1 = 15;
    rst_off();
    run_line(0, 0, "R10");
  endtask

  task automatic t_basic();
    rst_on();
    start_a = 3; start_b = 6; pat_m1 = 3; rep_even = 2; grp_sel = 8'he4;
    rst_off();
    run_line(0, 0, "R3");
    run_line(0, 0, "R3");
  endtask

  task automatic t_mapping();
    rst_on();
    grp_sel = 8'h1f; start_a = 1; start_b = 9; pat_m1 = 7; rep_even = 1;
    rst_off();
    run_line(0, 0, "R4");
    rst_on();
    grp_sel = 8'h9c; start_a = 5; start_b = 0; pat_m1 = 15;
    rst_off();
    run_line(0, 0, "R4");
  endtask

  task automatic t_odd_even();
    rst_on();
    pat_m1 = 2; rep_odd = 3; rep_even = 1; start_a = 2; start_b = 4;
    rst_off();
    run_line(1, 0, "R5");
    run_line(0, 0, "R5");
    run_line(1, 0, "R5");
    rst_on();
    pat_m1 = 2; rep_odd = 2; rep_even = 0;
    rst_off();
    run_line(0, 0, "R5");
    run_line(1, 0, "R5");
  endtask

  task automatic t_cut();
    rst_on();
    line_m1 = 19; last_m1 = 19; start_a = 15; start_b = 2; pat_m1 = 7; rep_even = 4;
    rst_off();
    run_line(0, 0, "R6");
    run_line(0, 0, "R6");
  endtask

  task automatic t_freeze();
    rst_on();
    line_m1 = 39; last_m1 = 39; start_a = 3; start_b = 5; pat_m1 = 5; rep_even = 3;
    mask_en = 1; frz_en = 2'b01; frz_pos = {13'd20, 13'd8}; res_pos = {13'd24, 13'd12};
    rst_off();
    run_line(0, 0, "R7");
    rst_on();
    line_m1 = 39; last_m1 = 39; start_a = 3; start_b = 5; pat_m1 = 5; rep_even = 3;
    mask_en = 1; frz_en = 2'b10; frz_pos = {13'd20, 13'd8}; res_pos = {13'd24, 13'd12};
    rst_off();
    run_line(0, 0, "R7");
    rst_on();
    line_m1 = 39; last_m1 = 39; start_a = 3; start_b = 5; pat_m1 = 5; rep_even = 3;
    mask_en = 1; frz_en = 2'b11; frz_pos = {13'd20, 13'd8}; res_pos = {13'd24, 13'd12};
    rst_off();
    run_line(0, 0, "R7");
    run_line(0, 0, "R7");
  endtask

  task automatic t_mask_off();
    rst_on();
    line_m1 = 39; last_m1 = 39; start_a = 3; start_b = 5; pat_m1 = 5; rep_even = 3;
    mask_en = 0; frz_en = 2'b11; frz_pos = {13'd20, 13'd8}; res_pos = {13'd24, 13'd12};
    rst_off();
    run_line(0, 0, "R8");
  endtask

  task automatic t_last();
    rst_on();
    line_m1 = 24; last_m1 = 11; start_a = 2; start_b = 3; pat_m1 = 3;
    rst_off();
    run_line(0, 0, "R2");
    run_line(1, 1, "R2");
    run_line(0, 0, "R2");
  endtask

  task automatic t_toggle();
    rst_on();
    tg_pol = 3'b101;
    tg_pos = {13'd50, 13'd3, 13'd7, 13'd0, 13'd10, 13'd4};
    rst_off();
    run_line(0, 0, "R9");
    rst_on();
    tg_pol = 3'b010;
    tg_pos = {13'd29, 13'd1, 13'd2, 13'd2, 13'd28, 13'd15};
    rst_off();
    run_line(0, 0, "R9");
  endtask

  initial begin
    for (int g = 0; g < NGRP; g++)
      for (int s = 0; s < NSTEP; s++)
        pat_tbl[(g*NSTEP + s)*NV +: NV] = patv(g, s);
    rst_on();
    t_reset();
    t_basic();
    t_mapping();
    t_odd_even();
    t_cut();
    t_freeze();
    t_mask_off();
    t_last();
    t_toggle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule